// File: doc/BRIEF.md
# Bit-Slip Alignment Search Controller

This block steers the slip input of a bit-slip word aligner until the aligner's parallel output carries a programmed alignment pattern. The pattern is twice as wide as one data word and is recognised across two consecutive words: the earlier word is compared with the lower half and the later word with the upper half. The controller requests one slip at a time and lets the aligner output settle before it looks again. It stops once the pattern is seen or once a bounded number of slips has been spent.

A search starts whenever `en` is high and `restart` is low. The controller first checks the current boundary without slipping. Each later check follows one single-cycle slip pulse and a fixed settle interval. A full data width of slips brings the boundary back to where it started. Because the checks all fall on the same word parity, the search allows two full rounds (2 x DATA_W slips) so that both word phases of the pattern are tried. On a match, `locked` goes high and no further slips are issued. If the budget runs out, `failed` goes high and the block stays idle. Dropping `en` or raising `restart` abandons the search and clears both flags.

Top module: `bitslip_align_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `slip_pulse`, `locked` and `failed` are all 0.
- R2: While `en` is 0, no slip pulse is issued and both flags stay 0, whatever the data.
- R3: Every slip pulse is high for exactly one clock cycle.
- R4: Within one search, successive slip pulses start exactly SLIP_GAP (default 4) cycles apart.
- R5: A match is `{rx_word, previous rx_word} == PATTERN`, where the later word is the upper half. The default is DATA_W=8 and PATTERN=16'b0000111100011110, so the earlier word is 8'b00011110 and the later word is 8'b00001111. On a match at a check, `locked` rises the next cycle, which is SLIP_GAP cycles after the last slip pulse. With any start offset of a periodic stream, lock is reached within 2 x DATA_W slips.
- R6: While `locked` is high and `en`=1, `restart`=0, `locked` stays high and no slip pulse is issued, whatever the data.
- R7: If no check matches, exactly 2 x DATA_W slips are issued. `failed` then rises SLIP_GAP cycles after the last of them, stays high, and no further slip follows.
- R8: `restart`=1 or `en`=0 clears `slip_pulse`, `locked` and `failed` by the next cycle. A search begun afterwards issues its first slip SLIP_GAP cycles after the start cycle when no match is seen.
- R9: `locked` and `failed` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Search enable; low holds the controller idle |
| restart | input | 1 | Abandon the current result and begin a new search |
| rx_word | input | DATA_W | Parallel word from the aligner output |
| slip_pulse | output | 1 | One-cycle slip request to the aligner |
| locked | output | 1 | Pattern found at the current boundary |
| failed | output | 1 | Slip budget spent with no match |

## Verification
A slip pulse becomes visible one cycle after the check that decided it. The next pulse is due SLIP_GAP cycles after the previous one. `locked` or `failed` is due SLIP_GAP cycles after the last pulse, and the flags clear one cycle after `restart` or a low `en`. The bench samples at the falling edge, indexes every cycle of a scenario, and compares the recorded pulse and flag cycles against these distances. It keeps a behavioural aligner that rotates a periodic pattern stream by one bit per observed pulse. From the words it drove in the two cycles before `locked` rose, it confirms that the lock came from a true match.

// File: rtl/align_pkg.sv
package align_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLIP   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_CHECK  = 3'd3,
    ST_LOCKED = 3'd4,
    ST_FAIL   = 3'd5
  } align_state_e;
endpackage

// File: rtl/align_rst_sync.sv
module align_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_sync = stage1_q;
endmodule

// File: rtl/align_pattern_match.sv
module align_pattern_match #(
  parameter int unsigned DATA_W = 8,
  parameter logic [2*DATA_W-1:0] PATTERN = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] word_i,
  output logic              match_o
);
  localparam int unsigned HALVES = 2;

  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] lane [HALVES];
  logic [HALVES-1:0] half_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else if (cap_en) begin
      prev_q <= word_i;
    end
  end

  // lane 0 is the earlier word (lower half), lane 1 the later word (upper half)
  assign lane[0] = prev_q;
  assign lane[1] = word_i;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_ok[h] = (lane[h] == PATTERN[h*DATA_W +: DATA_W]);
  end

  assign match_o = &half_ok;
endmodule

// File: rtl/align_settle_timer.sv
module align_settle_timer #(
  parameter int unsigned SLIP_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int unsigned LOAD_VAL = SLIP_GAP - 3;
  localparam int unsigned CNT_W    = (SLIP_GAP > 2) ? $clog2(SLIP_GAP) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(LOAD_VAL);
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/align_slip_counter.sv
module align_slip_counter #(
  parameter int unsigned MAX_SLIPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic spent
);
  localparam int unsigned CNT_W = $clog2(MAX_SLIPS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (inc && !spent) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign spent = (cnt_q == CNT_W'(MAX_SLIPS));
endmodule

// File: rtl/bitslip_align_ctrl.sv
module bitslip_align_ctrl #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLIP_GAP = 4,
  parameter logic [2*DATA_W-1:0] PATTERN = 16'b0000111100011110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [DATA_W-1:0] rx_word,
  output logic              slip_pulse,
  output logic              locked,
  output logic              failed
);
  import align_pkg::*;

  localparam int unsigned MAX_SLIPS = 2 * DATA_W;

  align_state_e state_q;
  align_state_e state_d;
  logic         rst_n_sync;
  logic         match;
  logic         settle_done;
  logic         budget_spent;
  logic         abort;

  align_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  align_pattern_match #(
    .DATA_W  (DATA_W),
    .PATTERN (PATTERN)
  ) u_match (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .cap_en  (en),
    .word_i  (rx_word),
    .match_o (match)
  );

  align_settle_timer #(
    .SLIP_GAP (SLIP_GAP)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (state_q != ST_WAIT),
    .run   (state_q == ST_WAIT),
    .done  (settle_done)
  );

  align_slip_counter #(
    .MAX_SLIPS (MAX_SLIPS)
  ) u_slips (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (state_q == ST_IDLE),
    .inc   (state_q == ST_SLIP),
    .spent (budget_spent)
  );

  assign abort = !en || restart;

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_WAIT;
        ST_SLIP:   state_d = ST_WAIT;
        ST_WAIT:   if (settle_done) state_d = ST_CHECK;
        ST_CHECK: begin
          if (match)             state_d = ST_LOCKED;
          else if (budget_spent) state_d = ST_FAIL;
          else                   state_d = ST_SLIP;
        end
        ST_LOCKED: state_d = ST_LOCKED;
        ST_FAIL:   state_d = ST_FAIL;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign slip_pulse = (state_q == ST_SLIP);
  assign locked     = (state_q == ST_LOCKED);
  assign failed     = (state_q == ST_FAIL);
endmodule

// File: rtl/align_ctrl_chk.sv
module align_ctrl_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLIP_GAP = 4,
  parameter logic [2*DATA_W-1:0] PATTERN = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              restart,
  input logic [DATA_W-1:0] rx_word,
  input logic              slip_pulse,
  input logic              locked,
  input logic              failed
);
  localparam int unsigned GAP_W = $clog2(SLIP_GAP + 1);

  logic [GAP_W-1:0] since_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (slip_pulse) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != GAP_W'(SLIP_GAP)) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!slip_pulse && !locked && !failed));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && seen_q) |-> (since_q >= GAP_W'(SLIP_GAP - 1)));

  p_lock_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ({$past(rx_word, 1), $past(rx_word, 2)} == PATTERN));

  p_quiet_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !slip_pulse);

  p_hold_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && en && !restart) |=> locked);

  p_quiet_failed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> !slip_pulse);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!slip_pulse && !locked && !failed));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && failed));
endmodule

bind bitslip_align_ctrl align_ctrl_chk #(
  .DATA_W   (DATA_W),
  .SLIP_GAP (SLIP_GAP),
  .PATTERN  (PATTERN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .restart    (restart),
  .rx_word    (rx_word),
  .slip_pulse (slip_pulse),
  .locked     (locked),
  .failed     (failed)
);

// File: tb/tb_bitslip_align_ctrl.sv
module tb_bitslip_align_ctrl;
  localparam int W   = 8;
  localparam int GAP = 4;
  localparam int MAXS = 2 * W;
  localparam logic [15:0] PAT = 16'b0000111100011110;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       restart;
  logic [7:0] rx_word;
  logic       slip_pulse;
  logic       locked;
  logic       failed;

  int checks = 0;
  int errors = 0;

  // behavioural aligner: 0 = rotating pattern stream, 1 = constant filler
  int         mode = 1;
  int         off  = 0;
  logic       ph   = 1'b0;
  logic [7:0] h0 = '0, h1 = '0, h2 = '0;

  bitslip_align_ctrl #(.DATA_W(W), .SLIP_GAP(GAP), .PATTERN(PAT)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart), .rx_word(rx_word),
    .slip_pulse(slip_pulse), .locked(locked), .failed(failed)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] model_word(input int o, input logic p);
    logic [31:0] dbl;
    logic [15:0] r;
    dbl = {PAT, PAT} >> o;
    r   = dbl[15:0];
    return p ? r[15:8] : r[7:0];
  endfunction

  initial rx_word = 8'h00;

  always @(posedge clk) begin
    #1;
    if (slip_pulse) off = (off + 1) % 16;
    ph = ~ph;
    h2 = h1;
    h1 = h0;
    h0 = (mode == 0) ? model_word(off, ph) : 8'hAA;
    rx_word = h0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b1; restart = 1'b0; mode = 1;
    repeat (3) @(negedge clk);
    chk(!slip_pulse && !locked && !failed, "R1 outputs in reset",
        {slip_pulse, locked, failed}, 0);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!slip_pulse && !locked && !failed, "R1 outputs after release",
        {slip_pulse, locked, failed}, 0);
  endtask

  task automatic t_disabled();
    int bad = 0;
    en = 1'b0; restart = 1'b0; mode = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (slip_pulse || locked || failed) bad++;
    end
    chk(bad == 0, "R2 quiet while disabled", bad, 0);
  endtask

  task automatic t_search(input int start_off);
    int np = 0, lastk = 0, lockk = 0, bad_w = 0, bad_g = 0, quiet = 0, lost = 0;
    bit prevp = 1'b0, words_ok = 1'b0;
    mode = 0; en = 1'b1; restart = 1'b1;
    repeat (2) @(negedge clk);
    off = start_off;
    restart = 1'b0;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (slip_pulse) begin
        if (prevp) bad_w++;
        if (np > 0 && (k - lastk) != GAP) bad_g++;
        np++;
        lastk = k;
      end
      prevp = slip_pulse;
      if (locked) begin
        lockk = k;
        words_ok = ({h1, h2} == PAT);
        break;
      end
    end
    chk(locked, "R5 lock reached", locked, 1);
    chk(words_ok, "R5 locked on true match", {h1, h2}, PAT);
    chk(np <= MAXS, "R5 slips within budget", np, MAXS);
    if (np > 0) chk((lockk - lastk) == GAP, "R5 lock latency after slip", lockk - lastk, GAP);
    chk(bad_w == 0, "R3 pulse width", bad_w, 0);
    chk(bad_g == 0, "R4 slip spacing", bad_g, 0);
    chk(!failed, "R9 flags exclusive on lock", failed, 0);
    mode = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (slip_pulse) quiet++;
      if (!locked) lost++;
    end
    chk(quiet == 0, "R6 no slips after lock", quiet, 0);
    chk(lost == 0, "R6 lock held on new data", lost, 0);
  endtask

  task automatic t_en_drop();
    en = 1'b0;
    @(negedge clk);
    chk(!locked && !failed && !slip_pulse, "R8 enable low clears",
        {slip_pulse, locked, failed}, 0);
  endtask

  task automatic t_fail();
    int np = 0, lastk = 0, failk = 0, bad_g = 0, extra = 0, lost = 0;
    mode = 1; en = 1'b1; restart = 1'b1;
    repeat (2) @(negedge clk);
    restart = 1'b0;
    for (int k = 1; k < 600; k++) begin
      @(negedge clk);
      if (slip_pulse) begin
        if (np > 0 && (k - lastk) != GAP) bad_g++;
        np++;
        lastk = k;
      end
      if (failed) begin
        failk = k;
        break;
      end
    end
    chk(failed, "R7 failure raised", failed, 1);
    chk(np == MAXS, "R7 slip count", np, MAXS);
    chk((failk - lastk) == GAP, "R7 failure latency", failk - lastk, GAP);
    chk(bad_g == 0, "R4 spacing during full search", bad_g, 0);
    chk(!locked, "R9 flags exclusive on fail", locked, 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (slip_pulse) extra++;
      if (!failed) lost++;
    end
    chk(extra == 0, "R7 no slips after failure", extra, 0);
    chk(lost == 0, "R7 failure held", lost, 0);
  endtask

  task automatic t_restart();
    int np = 0, bad = 0, firstk = 0;
    mode = 1; en = 1'b1; restart = 1'b1;
    repeat (2) @(negedge clk);
    restart = 1'b0;
    for (int k = 0; k < 100 && np < 3; k++) begin
      @(negedge clk);
      if (slip_pulse) np++;
    end
    restart = 1'b1;
    @(negedge clk);
    chk(!slip_pulse && !locked && !failed, "R8 restart clears",
        {slip_pulse, locked, failed}, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (slip_pulse || locked || failed) bad++;
    end
    chk(bad == 0, "R8 idle while restart held", bad, 0);
    restart = 1'b0;
    for (int k = 1; k < 20; k++) begin
      @(negedge clk);
      if (slip_pulse) begin
        firstk = k;
        break;
      end
    end
    chk(firstk == GAP, "R8 first slip after new start", firstk, GAP);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_search(0);
    t_search(5);
    t_search(13);
    t_en_drop();
    t_fail();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule